// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer reached over a plain 32-bit register bus (address, write data, write strobe, combinational read data). A 16-bit counter counts upward once per prescaled tick while the watchdog is enabled. When it steps past 0xFFFF it wraps to zero, latches a sticky overflow flag and raises a reset request for one clock. Software sets a timeout of N ticks by loading 65536 − N into the counter, then enables the timer. It keeps the system alive by reloading the counter before it wraps.

Every write has to carry a key in its upper bits, and the key depends on which register is addressed. A write without the right key changes nothing. A keyed write to the counter or to the main control register does not act at once. It is held as pending while a settle flag is high, and it takes effect when that flag drops, four prescaled ticks later. Software polls the flag before it enables the timer. The secondary control register is a plain keyed 8-bit store and takes writes at once.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter, both control registers and the settle flag read as zero, and the reset request is low.
- R2: A write to byte offset 0 whose bits 31:16 equal 0x5A5A loads bits 15:0 into the counter once the settle window ends.
- R3: A write to byte offset 4 (main control) or byte offset 8 (secondary control) is accepted only when bits 31:8 equal 0xA5A5A5, and bits 7:0 are the payload.
- R4: A write with the wrong key, or with the other register's key, changes no register and does not raise the settle flag.
- R5: Main control layout: bit 7 enable, bit 5 settle flag (read-only), bit 4 overflow, bits 2:0 divider code; bits 6 and 3 read zero. The secondary control register stores its 8-bit payload and reads it back on the next cycle.
- R6: An accepted counter or main-control write raises the settle flag for exactly 4 ticks of the divider in force, and the written value appears only when the flag drops. A further accepted write inside the window starts the window again.
- R7: Divider codes 0 to 7 select tick periods of 1, 4, 16, 32, 64, 128, 1024 and 4096 clocks. While enabled, the counter increments once per tick.
- R8: When the counter steps from 0xFFFF it becomes 0, the overflow flag sets and the reset request is high for exactly one clock. A load of 65536 − N gives the request N ticks after enable takes effect.
- R9: The overflow flag stays set until an accepted main-control write with bit 4 clear takes effect. Writing bit 4 as 1 never sets it.
- R10: Clearing enable freezes the count, and setting enable again resumes counting from the frozen value.
- R11: Reads at byte offset 0 return the live counter in bits 15:0, with bits 31:16 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write word: key in the upper bits, payload in the lower bits |
| bus_we | input | 1 | Write strobe, one write per clock it is high |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-clock reset request on counter wrap |

## Verification
A pending value that is lost, or applied at the wrong moment, shows at the ports as a settle flag whose length is off by a tick, or as a counter or control readback that changes too early. Both are visible in the first read after the window. A broken key decoder shows up in the very next readback of the targeted register. A wrong divider or increment path shifts the reset request away from the N-th tick after enable, which the timeout scenario catches at that cycle. A frozen count that drifts shows up as two reads taken twenty clocks apart that do not match.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   // register byte offsets; software depends on these
   localparam int OFS_CNT  = 0;
   localparam int OFS_CTLA = 4;
   localparam int OFS_CTLB = 8;

   // write keys
   localparam logic [15:0] CNT_KEY = 16'h5A5A;
   localparam logic [23:0] CTL_KEY = 24'hA5A5A5;

   // control-A bit positions
   localparam int EN_BIT   = 7;
   localparam int BUSY_BIT = 5;
   localparam int OVF_BIT  = 4;

   localparam int NUM_CODES = 8;

   // log2 of the tick divider for each clock-select code
   function automatic int div_log2(input int code);
      case (code)
         0:       return 0;
         1:       return 2;
         2:       return 4;
         3:       return 5;
         4:       return 6;
         5:       return 7;
         6:       return 10;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/kwdt_regif.sv
module kwdt_regif #(
   parameter int ADDR_W = 4,
   parameter int BUS_W  = 32,
   parameter int CNT_W  = 16
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_we,
   output logic              wr_cnt,
   output logic              wr_ctla,
   output logic              wr_ctlb
);
   import kwdt_pkg::*;

   logic cnt_key_ok;
   logic ctl_key_ok;
   logic hit_cnt, hit_ctla, hit_ctlb;

   assign cnt_key_ok = (bus_wdata[BUS_W-1:CNT_W] == CNT_KEY);
   assign ctl_key_ok = (bus_wdata[BUS_W-1:8] == CTL_KEY);

   assign hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
   assign hit_ctla = (bus_addr == ADDR_W'(OFS_CTLA));
   assign hit_ctlb = (bus_addr == ADDR_W'(OFS_CTLB));

   assign wr_cnt  = bus_we && hit_cnt  && cnt_key_ok;
   assign wr_ctla = bus_we && hit_ctla && ctl_key_ok;
   assign wr_ctlb = bus_we && hit_ctlb && ctl_key_ok;

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
   parameter int PRE_W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cks,
   output logic       tick
);
   import kwdt_pkg::*;

   logic [PRE_W-1:0]     pre_q;
   logic [NUM_CODES-1:0] tk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   // one tick decode per divider code; the powers of two let a mask replace a compare
   for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
      localparam int K = div_log2(i);
      if (K > PRE_W) begin : g_bad
         $error("kwdt_prescaler: PRE_W too small for divider code %0d", i);
      end
      if (K == 0) begin : g_one
         assign tk[i] = 1'b1;
      end else begin : g_mask
         assign tk[i] = &pre_q[K-1:0];
      end
   end

   assign tick = tk[cks];

endmodule

// File: rtl/kwdt_settle.sv
module kwdt_settle #(
   parameter int SETTLE_TICKS = 4,
   parameter int CNT_W        = 16,
   parameter int CTL_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_cnt,
   input  logic             wr_ctla,
   input  logic [CNT_W-1:0] wr_data,
   output logic             busy,
   output logic             apply_cnt,
   output logic             apply_ctla,
   output logic [CNT_W-1:0] pend_cnt,
   output logic [CTL_W-1:0] pend_ctla
);
   localparam int LEFT_W = $clog2(SETTLE_TICKS + 1);

   logic [LEFT_W-1:0] left_q;
   logic              busy_q, pcv_q, pav_q;
   logic [CNT_W-1:0]  pend_cnt_q;
   logic [CTL_W-1:0]  pend_ctla_q;
   logic              any_wr, apply;

   assign any_wr = wr_cnt | wr_ctla;
   // a fresh write in the last tick restarts the window instead of applying
   assign apply  = busy_q && tick && (left_q == LEFT_W'(1)) && !any_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q      <= '0;
         busy_q      <= 1'b0;
         pcv_q       <= 1'b0;
         pav_q       <= 1'b0;
         pend_cnt_q  <= '0;
         pend_ctla_q <= '0;
      end else begin
         if (wr_cnt) begin
            pend_cnt_q <= wr_data;
            pcv_q      <= 1'b1;
         end else if (apply) begin
            pcv_q      <= 1'b0;
         end
         if (wr_ctla) begin
            pend_ctla_q <= wr_data[CTL_W-1:0];
            pav_q       <= 1'b1;
         end else if (apply) begin
            pav_q       <= 1'b0;
         end
         if (any_wr) begin
            busy_q <= 1'b1;
            left_q <= LEFT_W'(SETTLE_TICKS);
         end else if (busy_q && tick) begin
            left_q <= left_q - 1'b1;
            if (left_q == LEFT_W'(1)) busy_q <= 1'b0;
         end
      end
   end

   assign busy       = busy_q;
   assign apply_cnt  = apply && pcv_q;
   assign apply_ctla = apply && pav_q;
   assign pend_cnt   = pend_cnt_q;
   assign pend_ctla  = pend_ctla_q;

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_evt,
   output logic             wrap_pulse
);
   logic [CNT_W-1:0] cnt_q;
   logic             pulse_q;

   // a load in the same cycle wins over the increment, so no wrap is reported
   assign wrap_evt = en && tick && !load && (cnt_q == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         if (load)           cnt_q <= load_val;
         else if (en && tick) cnt_q <= cnt_q + 1'b1;
         pulse_q <= wrap_evt;
      end
   end

   assign cnt        = cnt_q;
   assign wrap_pulse = pulse_q;

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
   parameter int ADDR_W       = 4,
   parameter int SETTLE_TICKS = 4,
   parameter int PRE_W        = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   output logic              rst_req
);
   import kwdt_pkg::*;

   localparam int BUS_W = 32;
   localparam int CNT_W = 16;
   localparam int CTL_W = 8;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("kwdt_top: ADDR_W must reach offset 8");
   end
   if (SETTLE_TICKS < 1) begin : g_bad_settle
      $error("kwdt_top: SETTLE_TICKS must be at least 1");
   end

   logic             wr_cnt, wr_ctla, wr_ctlb;
   logic             tick, busy, apply_cnt, apply_ctla;
   logic [CNT_W-1:0] pend_cnt, cnt_q;
   logic [CTL_W-1:0] pend_ctla;
   logic             wrap_evt;
   logic             en_q, ovf_q;
   logic [2:0]       cks_q;
   logic [CTL_W-1:0] ctlb_q;
   logic             unused_rsvd;

   assign unused_rsvd = ^{pend_ctla[6:5], pend_ctla[3]};

   kwdt_regif #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_regif (
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_we   (bus_we),
      .wr_cnt   (wr_cnt),
      .wr_ctla  (wr_ctla),
      .wr_ctlb  (wr_ctlb)
   );

   kwdt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .cks  (cks_q),
      .tick (tick)
   );

   kwdt_settle #(.SETTLE_TICKS(SETTLE_TICKS), .CNT_W(CNT_W), .CTL_W(CTL_W)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_cnt    (wr_cnt),
      .wr_ctla   (wr_ctla),
      .wr_data   (bus_wdata[CNT_W-1:0]),
      .busy      (busy),
      .apply_cnt (apply_cnt),
      .apply_ctla(apply_ctla),
      .pend_cnt  (pend_cnt),
      .pend_ctla (pend_ctla)
   );

   kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .tick      (tick),
      .load      (apply_cnt),
      .load_val  (pend_cnt),
      .cnt       (cnt_q),
      .wrap_evt  (wrap_evt),
      .wrap_pulse(rst_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         ovf_q  <= 1'b0;
         cks_q  <= '0;
         ctlb_q <= '0;
      end else begin
         if (apply_ctla) begin
            en_q  <= pend_ctla[EN_BIT];
            cks_q <= pend_ctla[2:0];
         end
         if (wrap_evt)                             ovf_q <= 1'b1;
         else if (apply_ctla && !pend_ctla[OVF_BIT]) ovf_q <= 1'b0;
         if (wr_ctlb) ctlb_q <= bus_wdata[CTL_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CNT):  bus_rdata[CNT_W-1:0] = cnt_q;
         ADDR_W'(OFS_CTLA): begin
            bus_rdata[EN_BIT]   = en_q;
            bus_rdata[BUSY_BIT] = busy;
            bus_rdata[OVF_BIT]  = ovf_q;
            bus_rdata[2:0]      = cks_q;
         end
         ADDR_W'(OFS_CTLB): bus_rdata[CTL_W-1:0] = ctlb_q;
         default:           bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_we,
   input logic              rst_req,
   input logic              busy,
   input logic              en,
   input logic              ovf,
   input logic [15:0]       cnt,
   input logic              apply_cnt,
   input logic              apply_ctla
);
   logic settle_wr;
   assign settle_wr = bus_we &&
      ((bus_addr == ADDR_W'(0) && bus_wdata[31:16] == 16'h5A5A) ||
       (bus_addr == ADDR_W'(4) && bus_wdata[31:8] == 24'hA5A5A5));

   AST_RST_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R8

   AST_WRAP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == 16'h0000 && ovf)); // R8

   AST_BADKEY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !settle_wr) |=> !busy); // R4

   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !apply_cnt) |=> $stable(cnt)); // R10

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !apply_ctla) |=> ovf); // R9

   AST_NO_APPLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(apply_cnt || apply_ctla)); // R6

endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .rst_req   (rst_req),
   .busy      (busy),
   .en        (en_q),
   .ovf       (ovf_q),
   .cnt       (cnt_q),
   .apply_cnt (apply_cnt),
   .apply_ctla(apply_ctla)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   kwdt_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // counts the cycles the settle flag is seen high
   task automatic wait_idle(output int cyc);
      logic [31:0] v;
      cyc = 0;
      for (int i = 0; i < 20000; i++) begin
         bus_rd(4'd4, v);
         if (!v[5]) break;
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      bus_rd(4'd0, v);  check(v == 32'h0, "R1 counter", v, 32'h0);
      bus_rd(4'd4, v);  check(v == 32'h0, "R1 ctrl A", v, 32'h0);
      bus_rd(4'd8, v);  check(v == 32'h0, "R1 ctrl B", v, 32'h0);
      check(rst_req == 1'b0, "R1 rst_req", {31'h0, rst_req}, 32'h0);
   endtask

   task automatic t_ctlb();
      logic [31:0] v;
      bus_wr(4'd8, 32'hA5A5A53C);
      bus_rd(4'd8, v);  check(v == 32'h3C, "R3 R5 ctrl B write", v, 32'h3C);
      bus_rd(4'd4, v);  check(v[5] == 1'b0, "R5 ctrl B no settle", v, 32'h0);
      bus_wr(4'd8, 32'hA5A5A4FF);
      bus_rd(4'd8, v);  check(v == 32'h3C, "R4 ctrl B bad key", v, 32'h3C);
   endtask

   task automatic t_load();
      logic [31:0] v;
      int c;
      bus_wr(4'd0, 32'h5A5A1234);
      bus_rd(4'd0, v);  check(v == 32'h0, "R6 not yet applied", v, 32'h0);
      wait_idle(c);     check(c == 4, "R6 settle length", c, 4);
      bus_rd(4'd0, v);  check(v == 32'h1234, "R2 R11 counter load", v, 32'h1234);
   endtask

   task automatic t_badkey();
      logic [31:0] v;
      bus_wr(4'd0, 32'h5A5B7777);
      bus_rd(4'd4, v);  check(v[5] == 1'b0, "R4 bad key no settle", v, 32'h0);
      bus_wr(4'd0, 32'hA5A5A580);
      bus_wr(4'd4, 32'h5A5A0080);
      bus_rd(4'd4, v);  check(v == 32'h0, "R4 swapped keys ctrl A", v, 32'h0);
      repeat (8) @(negedge clk);
      bus_rd(4'd0, v);  check(v == 32'h1234, "R4 counter kept", v, 32'h1234);
      bus_rd(4'd4, v);  check(v == 32'h0, "R4 ctrl A kept", v, 32'h0);
   endtask

   task automatic t_restart();
      logic [31:0] v;
      int c;
      bus_wr(4'd0, 32'h5A5A0010);
      @(negedge clk);
      bus_wr(4'd0, 32'h5A5A0020);
      bus_rd(4'd0, v);  check(v == 32'h1234, "R6 still old value", v, 32'h1234);
      wait_idle(c);     check(c == 4, "R6 window restarted", c, 4);
      bus_rd(4'd0, v);  check(v == 32'h20, "R6 last write wins", v, 32'h20);
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      int c, k;
      bus_wr(4'd0, 32'h5A5AFFFD);
      wait_idle(c);
      bus_wr(4'd4, 32'hA5A5A580);
      wait_idle(c);
      k = 0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (rst_req) begin k = i; break; end
      end
      check(k == 3, "R8 request after N ticks", k, 3);
      @(negedge clk);
      check(rst_req == 1'b0, "R8 one clock pulse", {31'h0, rst_req}, 32'h0);
      bus_rd(4'd4, v);  check(v == 32'h90, "R5 R8 overflow set", v, 32'h90);
   endtask

   task automatic t_ovf();
      logic [31:0] v;
      int c;
      bus_wr(4'd4, 32'hA5A5A590);
      wait_idle(c);
      bus_rd(4'd4, v);  check(v[4] == 1'b1, "R9 write 1 keeps flag", v, 32'h90);
      bus_wr(4'd4, 32'hA5A5A500);
      wait_idle(c);
      bus_rd(4'd4, v);  check(v == 32'h0, "R9 R10 flag cleared", v, 32'h0);
      bus_wr(4'd4, 32'hA5A5A510);
      wait_idle(c);
      bus_rd(4'd4, v);  check(v == 32'h0, "R9 write 1 never sets", v, 32'h0);
   endtask

   task automatic t_pause();
      logic [31:0] v, h;
      int c;
      bus_wr(4'd0, 32'h5A5A0100);
      wait_idle(c);
      bus_wr(4'd4, 32'hA5A5A580);
      wait_idle(c);
      repeat (10) @(negedge clk);
      bus_wr(4'd4, 32'hA5A5A500);
      wait_idle(c);
      bus_rd(4'd0, h);
      check(h > 32'h100, "R10 counted while on", h, 32'h101);
      repeat (20) @(negedge clk);
      bus_rd(4'd0, v);  check(v == h, "R10 frozen", v, h);
      bus_wr(4'd4, 32'hA5A5A580);
      wait_idle(c);
      bus_rd(4'd0, v);  check(v == h, "R10 resume from held", v, h);
      @(negedge clk);
      bus_rd(4'd0, v);  check(v == h + 1, "R10 R7 resumes counting", v, h + 1);
      bus_wr(4'd4, 32'hA5A5A500);
      wait_idle(c);
   endtask

   task automatic t_div(input int code, input int d);
      logic [31:0] v0, v;
      int c, gap, lim;
      bus_wr(4'd4, 32'hA5A5A500 | 32'(code));
      wait_idle(c);
      bus_wr(4'd4, 32'hA5A5A580 | 32'(code));
      wait_idle(c);
      check(c >= 3 * d + 1 && c <= 4 * d, $sformatf("R6 R7 settle at code %0d", code), c, 4 * d);
      bus_rd(4'd0, v0);
      lim = 2 * d + 4;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         bus_rd(4'd0, v);
         if (v != v0) break;
      end
      v0 = v; gap = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         gap++;
         bus_rd(4'd0, v);
         if (v != v0) break;
      end
      check(gap == d, $sformatf("R7 tick period code %0d", code), gap, d);
      check(v == v0 + 1, "R7 single step", v, v0 + 1);
      bus_wr(4'd4, 32'hA5A5A500);
      wait_idle(c);
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctlb();
      t_load();
      t_badkey();
      t_restart();
      t_timeout();
      t_ovf();
      t_pause();
      t_div(1, 4);
      t_div(3, 32);
      t_div(7, 4096);
      done = 1'b1;
      report();
   end

endmodule